// File: doc/BRIEF.md
# Pin Bank with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O bank controlled through a plain 32-bit register bus. Each pin can be an output, driven from a data register, or an input. A read-only status word shows the synchronized level on every pin, whatever its direction. Every pin also has an interrupt detector. A packed two-bit field picks low level, high level, rising edge or falling edge. A separate per-pin any-edge bit overrides that field so the pin reports both edges.

Detected events set bits in a pending register, and software clears those bits by writing ones. A mask register selects which pending bits reach the two interrupt outputs. One output covers the lower half of the pins and the other covers the upper half, so each half can be routed to its own interrupt line.

The bus is single-cycle. A write commits on the clock edge where `bus_we` is high. A read is combinational on `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is low, every register reads zero, `pin_oe` and `pin_out` are zero, and both interrupt outputs are low.
- R2: A write to offset 0x00 sets `pin_out` and a write to offset 0x04 sets `pin_oe` (1 = output) on the next edge; both read back unchanged.
- R3: Offset 0x08 returns the level on `pin_in` after a two-flop synchronizer, so a change is readable after the second rising edge, for input and output pins alike; writes to it have no effect.
- R4: Offsets 0x0C (pins 0–15) and 0x10 (pins 16–31) hold the trigger mode of pin n in bits [2*(n mod 16)+1 : 2*(n mod 16)], encoded 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge; both read back as written.
- R5: In a level mode the pending bit is set on every cycle that the synchronized level matches, so a write-1 clear does not stay cleared while the level holds.
- R6: In a rising or falling mode the pending bit is set only by that transition of the synchronized level, and the bit reads as set after the third rising edge following the input change (not after the second).
- R7: When a pin's bit at offset 0x1C is 1, both its rising and falling transitions set its pending bit and its two-bit mode field is ignored.
- R8: The pending register at offset 0x18 clears each bit written as 1, leaves bits written as 0 unchanged, and holds its bits when not written.
- R9: When a detected event and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: Offset 0x14 is the interrupt mask (1 = enabled). `irq_lo` is the OR over pins 0–15 of pending AND mask, and `irq_hi` is the same OR over pins 16–31.
- R11: Reads of offsets 0x20–0x3C return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, commits on the rising edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The bench measures the exact latency from a pin change to its pending bit. A design that detects edges on the raw input or skips one synchronizer stage would show the bit one edge early, and a design with an extra stage would show it late. It times a write-1 clear to land in the same cycle as a rising-edge event. A design that lets the clear win would lose that interrupt. It also clears a level-triggered bit while the level is still present: a design that latches level events once would read zero there. The any-edge override is exercised against a pin whose mode field says rising only, so a design that honours the field would miss the falling edge. The half split is checked by masking a single upper-half pin, which would reveal a design that ORs all 32 bits into both outputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned BUS_W = 32;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'd0,
      TRIG_HIGH = 2'd1,
      TRIG_RISE = 2'd2,
      TRIG_FALL = 2'd3
   } trig_e;

   localparam logic [7:0] OFF_DATA  = 8'h00;
   localparam logic [7:0] OFF_DIR   = 8'h04;
   localparam logic [7:0] OFF_PAD   = 8'h08;
   localparam logic [7:0] OFF_CFGL  = 8'h0C;
   localparam logic [7:0] OFF_CFGH  = 8'h10;
   localparam logic [7:0] OFF_MASK  = 8'h14;
   localparam logic [7:0] OFF_PEND  = 8'h18;
   localparam logic [7:0] OFF_ANYED = 8'h1C;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned N      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   logic [N-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   lvl,
   input  logic [2*N-1:0] cfg,
   input  logic [N-1:0]   any_edge,
   output logic [N-1:0]   evt
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      trig_e mode;
      logic  hit;
      logic  rose;
      logic  fell;

      assign mode = trig_e'(cfg[2*i +: 2]);
      assign rose = lvl[i] & ~prev_q[i];
      assign fell = ~lvl[i] & prev_q[i];

      always_comb begin
         if (any_edge[i]) begin
            hit = rose | fell;
         end else begin
            case (mode)
               TRIG_LOW:  hit = ~lvl[i];
               TRIG_HIGH: hit = lvl[i];
               TRIG_RISE: hit = rose;
               default:   hit = fell;
            endcase
         end
      end

      assign evt[i] = hit;
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [N-1:0]      pad_lvl,
   input  logic [N-1:0]      evt,
   output logic [N-1:0]      data_q,
   output logic [N-1:0]      dir_q,
   output logic [N-1:0]      cfg_lo_q,
   output logic [N-1:0]      cfg_hi_q,
   output logic [N-1:0]      mask_q,
   output logic [N-1:0]      any_q,
   output logic [N-1:0]      pend_q
);

   logic [7:0]   a8;
   logic [N-1:0] wd;
   logic [N-1:0] clr;

   assign a8 = 8'(bus_addr);
   assign wd = bus_wdata[N-1:0];
   assign clr = (bus_we && a8 == OFF_PEND) ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         dir_q    <= '0;
         cfg_lo_q <= '0;
         cfg_hi_q <= '0;
         mask_q   <= '0;
         any_q    <= '0;
      end else if (bus_we) begin
         case (a8)
            OFF_DATA:  data_q   <= wd;
            OFF_DIR:   dir_q    <= wd;
            OFF_CFGL:  cfg_lo_q <= wd;
            OFF_CFGH:  cfg_hi_q <= wd;
            OFF_MASK:  mask_q   <= wd;
            OFF_ANYED: any_q    <= wd;
            default:   ;
         endcase
      end
   end

   // new events are ORed in after the clear, so a same-cycle event survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | evt;
   end

   always_comb begin
      case (a8)
         OFF_DATA:  bus_rdata = BUS_W'(data_q);
         OFF_DIR:   bus_rdata = BUS_W'(dir_q);
         OFF_PAD:   bus_rdata = BUS_W'(pad_lvl);
         OFF_CFGL:  bus_rdata = BUS_W'(cfg_lo_q);
         OFF_CFGH:  bus_rdata = BUS_W'(cfg_hi_q);
         OFF_MASK:  bus_rdata = BUS_W'(mask_q);
         OFF_PEND:  bus_rdata = BUS_W'(pend_q);
         OFF_ANYED: bus_rdata = BUS_W'(any_q);
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq_lo,
   output logic                irq_hi
);

   localparam int unsigned HALF = NUM_PINS / 2;

   if (NUM_PINS != 32) begin : g_bad_pins
      $error("NUM_PINS must be 32 so each mode register packs 16 pins");
   end
   if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 6..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0]   lvl_sync;
   logic [NUM_PINS-1:0]   det_evt;
   logic [NUM_PINS-1:0]   data_q;
   logic [NUM_PINS-1:0]   dir_q;
   logic [NUM_PINS-1:0]   cfg_lo_q;
   logic [NUM_PINS-1:0]   cfg_hi_q;
   logic [NUM_PINS-1:0]   mask_q;
   logic [NUM_PINS-1:0]   any_q;
   logic [NUM_PINS-1:0]   stat_q;
   logic [2*NUM_PINS-1:0] cfg_all;
   logic [NUM_PINS-1:0]   live;

   gpio_irq_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_sync)
   );

   assign cfg_all = {cfg_hi_q, cfg_lo_q};

   gpio_irq_detect #(.N(NUM_PINS)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .cfg      (cfg_all),
      .any_edge (any_q),
      .evt      (det_evt)
   );

   gpio_irq_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_lvl   (lvl_sync),
      .evt       (det_evt),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .cfg_lo_q  (cfg_lo_q),
      .cfg_hi_q  (cfg_hi_q),
      .mask_q    (mask_q),
      .any_q     (any_q),
      .pend_q    (stat_q)
   );

   assign pin_out = data_q;
   assign pin_oe  = dir_q;
   assign live    = stat_q & mask_q;
   assign irq_lo  = |live[HALF-1:0];
   assign irq_hi  = |live[NUM_PINS-1:HALF];

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BUS_W-1:0]    bus_wdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                irq_lo,
   input logic                irq_hi,
   input logic [NUM_PINS-1:0] evt,
   input logic [NUM_PINS-1:0] stat,
   input logic [NUM_PINS-1:0] mask
);

   logic [7:0] a8;
   assign a8 = 8'(bus_addr);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (pin_oe == '0 && pin_out == '0 && !irq_lo && !irq_hi)
            else $error("outputs active during reset");
      end
   end

   p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && a8 == OFF_DATA) |=> (pin_out == $past(bus_wdata[NUM_PINS-1:0])));

   p_dir_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && a8 == OFF_DIR) |=> (pin_oe == $past(bus_wdata[NUM_PINS-1:0])));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && a8 == OFF_PEND) |=>
         ((stat & $past(bus_wdata[NUM_PINS-1:0] & ~evt)) == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && a8 == OFF_PEND) |=> ((stat & $past(stat)) == $past(stat)));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> (!irq_lo && !irq_hi));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_lo    (irq_lo),
   .irq_hi    (irq_hi),
   .evt       (det_evt),
   .stat      (stat_q),
   .mask      (mask_q)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq_lo;
   logic        irq_hi;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_port dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   // reference model built from the requirements
   logic [31:0] m_s1, m_s2, m_p, m_stat;
   logic [31:0] m_data, m_dir, m_cl, m_ch, m_mask, m_any;

   function automatic logic trig_hit(logic [1:0] md, logic any, logic cur, logic prv);
      if (any) return cur ^ prv;
      case (md)
         2'd0:    return !cur;
         2'd1:    return cur;
         2'd2:    return cur & !prv;
         default: return !cur & prv;
      endcase
   endfunction

   function automatic logic [31:0] model_events();
      logic [31:0] e;
      logic [63:0] c;
      c = {m_ch, m_cl};
      for (int i = 0; i < 32; i++) e[i] = trig_hit(c[2*i +: 2], m_any[i], m_s2[i], m_p[i]);
      return e;
   endfunction

   function automatic logic [31:0] model_rd(logic [5:0] a);
      case (a)
         6'h00: return m_data;
         6'h04: return m_dir;
         6'h08: return m_s2;
         6'h0C: return m_cl;
         6'h10: return m_ch;
         6'h14: return m_mask;
         6'h18: return m_stat;
         6'h1C: return m_any;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_stat <= '0;
         m_data <= '0; m_dir <= '0; m_cl <= '0; m_ch <= '0; m_mask <= '0; m_any <= '0;
      end else begin
         m_stat <= (m_stat & ~((bus_we && bus_addr == 6'h18) ? bus_wdata : 32'h0)) | model_events();
         m_p  <= m_s2;
         m_s2 <= m_s1;
         m_s1 <= pin_in;
         if (bus_we) begin
            case (bus_addr)
               6'h00: m_data <= bus_wdata;
               6'h04: m_dir  <= bus_wdata;
               6'h0C: m_cl   <= bus_wdata;
               6'h10: m_ch   <= bus_wdata;
               6'h14: m_mask <= bus_wdata;
               6'h1C: m_any  <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog: actual %0d cycles, expected fewer than 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      peek(a, d);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = v;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic drive_pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));

      // R1: reset state
      repeat (3) @(negedge clk);
      for (int a = 0; a < 32; a += 4) begin
         peek(6'(a), d);
         chk("R1 register reads zero in reset", d, 32'h0);
      end
      chk("R1 pin_oe in reset", pin_oe, 32'h0);
      chk("R1 pin_out in reset", pin_out, 32'h0);
      chk("R1 irqs in reset", {30'h0, irq_hi, irq_lo}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: data and direction
      wr(6'h00, 32'hA5A5_0F0F);
      wr(6'h04, 32'hFFFF_0000);
      chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
      chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
      peek(6'h00, d); chk("R2 data readback", d, 32'hA5A5_0F0F);
      peek(6'h04, d); chk("R2 dir readback", d, 32'hFFFF_0000);

      // R3: pad level through the synchronizer, regardless of direction
      drive_pins(32'h1234_5678);
      @(negedge clk);
      peek(6'h08, d); chk("R3 pad not yet visible after one edge", d, 32'h0);
      @(negedge clk);
      peek(6'h08, d); chk("R3 pad visible after two edges", d, 32'h1234_5678);
      wr(6'h08, 32'h0);
      peek(6'h08, d); chk("R3 pad write ignored", d, 32'h1234_5678);

      // R4: mode register readback
      wr(6'h10, 32'h0000_0008);
      peek(6'h10, d); chk("R4 mode high readback", d, 32'h0000_0008);
      wr(6'h0C, 32'h1234_5678);
      peek(6'h0C, d); chk("R4 mode low readback", d, 32'h1234_5678);

      // setup: all rising, all enabled, quiet pins, clean pending
      drive_pins(32'h0);
      repeat (4) @(negedge clk);
      wr(6'h0C, 32'hAAAA_AAAA);
      wr(6'h10, 32'hAAAA_AAAA);
      wr(6'h1C, 32'h0);
      wr(6'h14, 32'hFFFF_FFFF);
      wr(6'h18, 32'hFFFF_FFFF);
      peek(6'h18, d); chk("R8 write all ones clears", d, 32'h0);

      // R6: rising edge on pin 17, latency of three edges
      drive_pins(32'h0002_0000);
      @(negedge clk);
      @(negedge clk);
      peek(6'h18, d); chk("R6 not pending after two edges", d, 32'h0);
      @(negedge clk);
      peek(6'h18, d); chk("R6 pending after three edges", d, 32'h0002_0000);
      chk("R10 upper irq from pin 17", {30'h0, irq_hi, irq_lo}, 32'h2);

      // R10: masking one pin
      wr(6'h14, 32'hFFFD_FFFF);
      chk("R10 pin 17 masked", {30'h0, irq_hi, irq_lo}, 32'h0);
      wr(6'h14, 32'hFFFF_FFFF);
      chk("R10 pin 17 unmasked", {30'h0, irq_hi, irq_lo}, 32'h2);

      wr(6'h18, 32'h0002_0000);
      drive_pins(32'h0);
      repeat (4) @(negedge clk);
      peek(6'h18, d); chk("R6 falling ignored in rising mode", d, 32'h0);

      // R7: any-edge override
      wr(6'h1C, 32'h0002_0000);
      drive_pins(32'h0002_0000);
      repeat (3) @(negedge clk);
      peek(6'h18, d); chk("R7 any-edge rise", d, 32'h0002_0000);
      wr(6'h18, 32'hFFFF_FFFF);
      drive_pins(32'h0);
      repeat (3) @(negedge clk);
      peek(6'h18, d); chk("R7 any-edge fall despite rising mode", d, 32'h0002_0000);
      wr(6'h18, 32'hFFFF_FFFF);
      wr(6'h1C, 32'h0);

      // R9: clear lands in the same cycle as an edge event on pin 20
      drive_pins(32'h0010_0000);
      @(negedge clk);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'h18; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      bus_we = 1'b0;
      peek(6'h18, d); chk("R9 set wins over clear", d, 32'h0010_0000);
      wr(6'h18, 32'hFFFF_FFFF);
      drive_pins(32'h0);
      repeat (4) @(negedge clk);
      wr(6'h18, 32'hFFFF_FFFF);

      // R5: high level on pin 3
      wr(6'h0C, 32'hAAAA_AA6A);
      drive_pins(32'h0000_0008);
      repeat (3) @(negedge clk);
      peek(6'h18, d); chk("R5 high level pending", d, 32'h0000_0008);
      wr(6'h18, 32'h0000_0008);
      peek(6'h18, d); chk("R5 level re-sets after clear", d, 32'h0000_0008);
      drive_pins(32'h0);
      repeat (3) @(negedge clk);
      wr(6'h18, 32'hFFFF_FFFF);
      peek(6'h18, d); chk("R5 clear sticks once level is gone", d, 32'h0);

      // R5: low level on pin 4
      wr(6'h0C, 32'hAAAA_A86A);
      repeat (2) @(negedge clk);
      wr(6'h18, 32'hFFFF_FFFF);
      peek(6'h18, d); chk("R5 low level re-sets", d, 32'h0000_0010);
      wr(6'h0C, 32'hAAAA_AA6A);
      wr(6'h18, 32'hFFFF_FFFF);

      // R8: partial clears
      drive_pins(32'h0000_0101);
      repeat (3) @(negedge clk);
      wr(6'h18, 32'h0);
      peek(6'h18, d); chk("R8 zero bits leave pending", d, 32'h0000_0101);
      wr(6'h18, 32'h0000_0001);
      peek(6'h18, d); chk("R8 single-bit clear", d, 32'h0000_0100);
      wr(6'h18, 32'hFFFF_FFFF);
      peek(6'h18, d); chk("R8 all-ones clear", d, 32'h0);

      // R11: unmapped offsets
      rd(6'h20, d); chk("R11 read 0x20", d, 32'h0);
      rd(6'h3C, d); chk("R11 read 0x3C", d, 32'h0);
      wr(6'h24, 32'h0);
      peek(6'h14, d); chk("R11 unmapped write leaves mask", d, 32'hFFFF_FFFF);
      peek(6'h00, d); chk("R11 unmapped write leaves data", d, 32'hA5A5_0F0F);

      // random phase against the model (covers R2..R10 together)
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         pin_in = pin_in ^ ($urandom & $urandom & $urandom);
         if ($urandom_range(0, 2) == 0) begin
            bus_we = 1'b1;
            case ($urandom_range(0, 8))
               0: bus_addr = 6'h00;
               1: bus_addr = 6'h04;
               2: bus_addr = 6'h0C;
               3: bus_addr = 6'h10;
               4: bus_addr = 6'h14;
               5: bus_addr = 6'h18;
               6: bus_addr = 6'h1C;
               7: bus_addr = 6'h08;
               default: bus_addr = 6'h24;
            endcase
            bus_wdata = $urandom;
         end else begin
            bus_we = 1'b0;
            bus_addr = 6'($urandom_range(0, 15) * 4);
         end
         #1;
         chk("R8 random readback", bus_rdata, model_rd(bus_addr));
         chk("R10 random irq", {30'h0, irq_hi, irq_lo},
             {30'h0, |(m_stat[31:16] & m_mask[31:16]), |(m_stat[15:0] & m_mask[15:0])});
         chk("R2 random pins", pin_out ^ pin_oe, m_data ^ m_dir);
      end
      @(negedge clk);
      bus_we = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule